// File: doc/BRIEF.md
# Write-Back Cache Atomic Ordering Controller

This block sits in front of the line-state tags of a GPU second-level cache and decides what happens to each incoming read, write or atomic request. Every atomic is treated as system scope. It is never executed inside the cache and always travels on to the directory. In write-through mode (the default) writes also go to the directory and lines never turn dirty. In write-back mode writes stay local and mark the line dirty.

An atomic that finds its line dirty cannot leave at once. The controller first launches a write-back of the line, claims a transaction entry and marks the line as waiting for the write-back acknowledgement. It then parks the atomic in a small stall buffer. When the acknowledgement comes back, the line returns to invalid, its transaction entry is released and every parked request for that line is woken. The woken requests are replayed oldest first, so the atomic reaches the directory strictly after memory has accepted the dirty data. Later requests to the waiting line queue up behind it, while requests to other lines keep being served.

Top module: `wb_atomic_order_ctrl`

## Requirements
- R1: After reset no write-back and no directory request is valid, and the request input is ready.
- R2: An atomic (reqOp 2) whose line is neither dirty nor waiting is sent to the directory port with dirOp 2 and its own address and tag. No write-back is issued.
- R3: In write-back mode, an atomic to a dirty line issues a write-back of that line's address. No directory request is made for that atomic until a write-back acknowledgement for the line has arrived.
- R4: A parked atomic reaches the directory only after the write-back of its line has been handshaken and acknowledged.
- R5: Requests to a line that waits for an acknowledgement, or that has requests still parked, are parked in arrival order and replayed oldest first after the wake. A replayed write makes the line dirty again, and a replayed atomic then triggers a fresh write-back.
- R6: While one line waits for its acknowledgement, an atomic to a different clean line is forwarded to the directory without waiting.
- R7: With wbEnable low, a write (reqOp 1) is sent to the directory with dirOp 1 and leaves the line clean. A following atomic to that line goes straight to the directory.
- R8: With wbEnable high, a write produces no directory request.
- R9: While dirValid is high and dirReady low, dirValid stays high and dirOp, dirAddr and dirId hold their values.
- R10: When the stall buffer holds STALL_DEPTH entries, reqReady is low. It rises again after a wake lets the entries drain.
- R11: When all NUM_TBE transaction entries are in use, reqReady is low until an acknowledgement frees one.
- R12: While wbValid is high and wbReady low, wbValid and wbAddr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbEnable | input | 1 | 1 selects write-back mode, 0 selects write-through |
| reqValid | input | 1 | Upstream request present |
| reqReady | output | 1 | Upstream request accepted this cycle when high with reqValid |
| reqOp | input | 2 | 0 read, 1 write, 2 atomic |
| reqAddr | input | ADDR_W | Line address of the request |
| reqId | input | ID_W | Request tag carried to the directory |
| wbValid | output | 1 | Write-back request to memory |
| wbReady | input | 1 | Memory accepts the write-back |
| wbAddr | output | ADDR_W | Line address being written back |
| wbAckValid | input | 1 | Write-back acknowledgement strobe |
| wbAckAddr | input | ADDR_W | Line address acknowledged |
| dirValid | output | 1 | Request to the directory |
| dirReady | input | 1 | Directory accepts the request |
| dirOp | output | 2 | 1 write, 2 atomic |
| dirAddr | output | ADDR_W | Line address of the directory request |
| dirId | output | ID_W | Tag of the forwarded request |

## Verification
The assertions assume that memory acknowledges only lines it has been asked to write back, each exactly once, and that the acknowledgement address names a line that is still waiting. The tag accounting and replay checks rely on this. The directed stimulus issues an acknowledgement only after the matching write-back handshake has been logged, and never for an idle line. It also changes wbEnable only while no line is waiting. The stall windows on dirReady and wbReady are opened and closed by the bench at falling edges, so a held request always sees its ready rise eventually.

// File: rtl/wbao_pkg.sv
package wbao_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ATOMIC = 2'd2
  } reqOp_e;

  typedef enum logic [2:0] {
    LN_I  = 3'd0,
    LN_V  = 3'd1,
    LN_M  = 3'd2,
    LN_W  = 3'd3,
    LN_WI = 3'd4
  } lineState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic park;     // append selected upstream request to stall buffer
    logic pop;      // remove the replayed entry
    logic sleep;    // clear wake flags of entries matching selected address
    logic sendDir;  // load directory output register
    logic sendWb;   // load write-back output register
  } dpStrobe_t;

endpackage

// File: rtl/wbao_ctrl.sv
module wbao_ctrl
  import wbao_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int ID_W    = 4,
  parameter int NUM_TBE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wbEnable,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [ID_W-1:0]     reqId,
  output logic                reqReady,
  input  logic                replayValid,
  input  logic [1:0]          replayOp,
  input  logic [ADDR_W-1:0]   replayAddr,
  input  logic [ID_W-1:0]     replayId,
  input  logic [(1<<ADDR_W)-1:0] pendLines,
  input  logic                bufFull,
  input  logic                dirBusy,
  input  logic                wbBusy,
  input  logic                ackValid,
  input  logic [ADDR_W-1:0]   ackAddr,
  output dpStrobe_t           strobe,
  output logic [1:0]          selOp,
  output logic [ADDR_W-1:0]   selAddr,
  output logic [ID_W-1:0]     selId
);

  localparam int NUM_LINES = 1 << ADDR_W;
  localparam int TBE_IDX_W = (NUM_TBE > 1) ? $clog2(NUM_TBE) : 1;

  lineState_e              lineState [NUM_LINES];
  logic [NUM_TBE-1:0]      tbeValid;
  logic [ADDR_W-1:0]       tbeAddr [NUM_TBE];

  logic                    tbeAvail;
  logic [TBE_IDX_W-1:0]    tbeFreeIdx;
  logic                    canProcess;
  logic                    useReplay;
  lineState_e              curState;
  logic                    blocked;
  logic                    isDirty;
  logic                    needTbe;
  logic                    go;
  logic                    lineWr;
  lineState_e              lineNext;
  logic                    allocTbe;
  logic [NUM_LINES-1:0]    isWi;

  // lowest free transaction entry
  always_comb begin
    tbeAvail   = 1'b0;
    tbeFreeIdx = '0;
    for (int t = NUM_TBE - 1; t >= 0; t--) begin
      if (!tbeValid[t]) begin
        tbeAvail   = 1'b1;
        tbeFreeIdx = TBE_IDX_W'(t);
      end
    end
  end

  // an acknowledgement owns the cycle; outputs must be free to launch work
  assign canProcess = !ackValid && !dirBusy && !wbBusy;
  assign useReplay  = replayValid;

  assign selOp   = useReplay ? replayOp   : reqOp;
  assign selAddr = useReplay ? replayAddr : reqAddr;
  assign selId   = useReplay ? replayId   : reqId;

  assign curState = lineState[selAddr];
  assign isDirty  = (curState == LN_M) || (curState == LN_W);
  assign blocked  = (curState == LN_WI) || (!useReplay && pendLines[selAddr]);
  assign needTbe  = !blocked && (selOp == OP_ATOMIC) && isDirty;

  assign reqReady = canProcess && !replayValid && !bufFull && tbeAvail;
  assign go = useReplay ? (canProcess && !(needTbe && !tbeAvail))
                        : (reqValid && reqReady);

  always_comb begin
    strobe   = '0;
    lineWr   = 1'b0;
    lineNext = curState;
    allocTbe = 1'b0;
    if (go) begin
      if (blocked) begin
        if (useReplay) strobe.sleep = 1'b1;
        else           strobe.park  = 1'b1;
      end else begin
        unique case (selOp)
          OP_ATOMIC: begin
            lineWr = 1'b1;
            if (isDirty) begin
              // flush first, hold the atomic until the ack wakes it
              strobe.sendWb = 1'b1;
              strobe.sleep  = 1'b1;
              strobe.park   = !useReplay;
              allocTbe      = 1'b1;
              lineNext      = LN_WI;
            end else begin
              strobe.sendDir = 1'b1;
              strobe.pop     = useReplay;
              lineNext       = LN_I;
            end
          end
          OP_WRITE: begin
            lineWr     = 1'b1;
            strobe.pop = useReplay;
            if (wbEnable) begin
              lineNext = (curState == LN_I) ? LN_W : LN_M;
            end else begin
              strobe.sendDir = 1'b1;
              lineNext       = LN_V;
            end
          end
          default: begin
            strobe.pop = useReplay;
            if (curState == LN_I) begin
              lineWr   = 1'b1;
              lineNext = LN_V;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINES; l++) lineState[l] <= LN_I;
      tbeValid <= '0;
      for (int t = 0; t < NUM_TBE; t++) tbeAddr[t] <= '0;
    end else if (ackValid) begin
      if (lineState[ackAddr] == LN_WI) lineState[ackAddr] <= LN_I;
      for (int t = 0; t < NUM_TBE; t++) begin
        if (tbeValid[t] && (tbeAddr[t] == ackAddr)) tbeValid[t] <= 1'b0;
      end
    end else begin
      if (lineWr) lineState[selAddr] <= lineNext;
      if (allocTbe) begin
        tbeValid[tbeFreeIdx] <= 1'b1;
        tbeAddr[tbeFreeIdx]  <= selAddr;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) isWi[l] = (lineState[l] == LN_WI);
  end

  // R3
  wb_enters_wi_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendWb |=> (lineState[$past(selAddr)] == LN_WI));

  // R4
  atomic_not_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sendDir && selOp == OP_ATOMIC) |-> (lineState[selAddr] != LN_WI));

  // R11
  tbe_tracks_wi_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tbeValid) == $countones(isWi));

endmodule

// File: rtl/wbao_dpath.sv
module wbao_dpath
  import wbao_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int ID_W        = 4,
  parameter int STALL_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [1:0]             selOp,
  input  logic [ADDR_W-1:0]      selAddr,
  input  logic [ID_W-1:0]        selId,
  input  logic                   ackValid,
  input  logic [ADDR_W-1:0]      ackAddr,
  input  logic                   dirReady,
  input  logic                   wbReady,
  output logic                   replayValid,
  output logic [1:0]             replayOp,
  output logic [ADDR_W-1:0]      replayAddr,
  output logic [ID_W-1:0]        replayId,
  output logic [(1<<ADDR_W)-1:0] pendLines,
  output logic                   bufFull,
  output logic                   dirValid,
  output logic [1:0]             dirOp,
  output logic [ADDR_W-1:0]      dirAddr,
  output logic [ID_W-1:0]        dirId,
  output logic                   wbValid,
  output logic [ADDR_W-1:0]      wbAddr
);

  localparam int NUM_LINES = 1 << ADDR_W;
  localparam int IDX_W     = (STALL_DEPTH > 1) ? $clog2(STALL_DEPTH) : 1;
  localparam int CNT_W     = $clog2(STALL_DEPTH + 1);

  // entries are kept compacted; lower index means older
  logic                entValid [STALL_DEPTH];
  logic                entWoken [STALL_DEPTH];
  logic [1:0]          entOp    [STALL_DEPTH];
  logic [ADDR_W-1:0]   entAddr  [STALL_DEPTH];
  logic [ID_W-1:0]     entId    [STALL_DEPTH];
  logic [CNT_W-1:0]    count;
  logic [IDX_W-1:0]    replayIdx;

  assign bufFull = (count == CNT_W'(STALL_DEPTH));

  always_comb begin
    replayValid = 1'b0;
    replayIdx   = '0;
    for (int i = STALL_DEPTH - 1; i >= 0; i--) begin
      if (entValid[i] && entWoken[i]) begin
        replayValid = 1'b1;
        replayIdx   = IDX_W'(i);
      end
    end
  end

  assign replayOp   = entOp[replayIdx];
  assign replayAddr = entAddr[replayIdx];
  assign replayId   = entId[replayIdx];

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      pendLines[l] = 1'b0;
      for (int i = 0; i < STALL_DEPTH; i++) begin
        if (entValid[i] && (entAddr[i] == ADDR_W'(l))) pendLines[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STALL_DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entWoken[i] <= 1'b0;
        entOp[i]    <= '0;
        entAddr[i]  <= '0;
        entId[i]    <= '0;
      end
      count <= '0;
    end else begin
      if (ackValid) begin
        for (int i = 0; i < STALL_DEPTH; i++) begin
          if (entValid[i] && (entAddr[i] == ackAddr)) entWoken[i] <= 1'b1;
        end
      end
      if (strobe.sleep) begin
        for (int i = 0; i < STALL_DEPTH; i++) begin
          if (entAddr[i] == selAddr) entWoken[i] <= 1'b0;
        end
      end
      if (strobe.pop) begin
        for (int i = 0; i < STALL_DEPTH; i++) begin
          if (i >= int'(replayIdx)) begin
            if (i < STALL_DEPTH - 1) begin
              entValid[i] <= entValid[i+1];
              entWoken[i] <= entWoken[i+1];
              entOp[i]    <= entOp[i+1];
              entAddr[i]  <= entAddr[i+1];
              entId[i]    <= entId[i+1];
            end else begin
              entValid[i] <= 1'b0;
              entWoken[i] <= 1'b0;
            end
          end
        end
        count <= count - 1'b1;
      end
      if (strobe.park) begin
        entValid[count[IDX_W-1:0]] <= 1'b1;
        entWoken[count[IDX_W-1:0]] <= 1'b0;
        entOp[count[IDX_W-1:0]]    <= selOp;
        entAddr[count[IDX_W-1:0]]  <= selAddr;
        entId[count[IDX_W-1:0]]    <= selId;
        count <= count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirValid <= 1'b0;
      dirOp    <= '0;
      dirAddr  <= '0;
      dirId    <= '0;
    end else if (strobe.sendDir) begin
      dirValid <= 1'b1;
      dirOp    <= selOp;
      dirAddr  <= selAddr;
      dirId    <= selId;
    end else if (dirValid && dirReady) begin
      dirValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
    end else if (strobe.sendWb) begin
      wbValid <= 1'b1;
      wbAddr  <= selAddr;
    end else if (wbValid && wbReady) begin
      wbValid <= 1'b0;
    end
  end

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirValid && !dirReady) |=> (dirValid && $stable(dirOp) &&
                                 $stable(dirAddr) && $stable(dirId)));

  // R12
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr)));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !strobe.park);

  // R5
  pop_woken_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> replayValid);

endmodule

// File: rtl/wb_atomic_order_ctrl.sv
module wb_atomic_order_ctrl
  import wbao_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int ID_W        = 4,
  parameter int STALL_DEPTH = 4,
  parameter int NUM_TBE     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbEnable,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqId,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbAckValid,
  input  logic [ADDR_W-1:0] wbAckAddr,
  output logic              dirValid,
  input  logic              dirReady,
  output logic [1:0]        dirOp,
  output logic [ADDR_W-1:0] dirAddr,
  output logic [ID_W-1:0]   dirId
);

  localparam int NUM_LINES = 1 << ADDR_W;

  dpStrobe_t             strobe;
  logic [1:0]            selOp;
  logic [ADDR_W-1:0]     selAddr;
  logic [ID_W-1:0]       selId;
  logic                  replayValid;
  logic [1:0]            replayOp;
  logic [ADDR_W-1:0]     replayAddr;
  logic [ID_W-1:0]       replayId;
  logic [NUM_LINES-1:0]  pendLines;
  logic                  bufFull;

  wbao_ctrl #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .NUM_TBE(NUM_TBE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wbEnable   (wbEnable),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqId      (reqId),
    .reqReady   (reqReady),
    .replayValid(replayValid),
    .replayOp   (replayOp),
    .replayAddr (replayAddr),
    .replayId   (replayId),
    .pendLines  (pendLines),
    .bufFull    (bufFull),
    .dirBusy    (dirValid),
    .wbBusy     (wbValid),
    .ackValid   (wbAckValid),
    .ackAddr    (wbAckAddr),
    .strobe     (strobe),
    .selOp      (selOp),
    .selAddr    (selAddr),
    .selId      (selId)
  );

  wbao_dpath #(
    .ADDR_W     (ADDR_W),
    .ID_W       (ID_W),
    .STALL_DEPTH(STALL_DEPTH)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .selOp      (selOp),
    .selAddr    (selAddr),
    .selId      (selId),
    .ackValid   (wbAckValid),
    .ackAddr    (wbAckAddr),
    .dirReady   (dirReady),
    .wbReady    (wbReady),
    .replayValid(replayValid),
    .replayOp   (replayOp),
    .replayAddr (replayAddr),
    .replayId   (replayId),
    .pendLines  (pendLines),
    .bufFull    (bufFull),
    .dirValid   (dirValid),
    .dirOp      (dirOp),
    .dirAddr    (dirAddr),
    .dirId      (dirId),
    .wbValid    (wbValid),
    .wbAddr     (wbAddr)
  );

endmodule

// File: tb/tb_wb_atomic_order_ctrl.sv
module tb_wb_atomic_order_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wbEnable = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqOp = '0;
  logic [1:0] reqAddr = '0;
  logic [3:0] reqId = '0;
  logic       wbValid;
  logic       wbReady = 1'b1;
  logic [1:0] wbAddr;
  logic       wbAckValid = 1'b0;
  logic [1:0] wbAckAddr = '0;
  logic       dirValid;
  logic       dirReady = 1'b1;
  logic [1:0] dirOp;
  logic [1:0] dirAddr;
  logic [3:0] dirId;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int dirCnt = 0;
  int dirOpLog [64];
  int dirAddrLog [64];
  int dirIdLog [64];
  int dirStamp [64];
  int wbCnt = 0;
  int wbAddrLog [64];
  int wbStamp [64];

  wb_atomic_order_ctrl dut (
    .clk(clk), .rstN(rstN), .wbEnable(wbEnable),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqId(reqId),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr),
    .wbAckValid(wbAckValid), .wbAckAddr(wbAckAddr),
    .dirValid(dirValid), .dirReady(dirReady), .dirOp(dirOp),
    .dirAddr(dirAddr), .dirId(dirId)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  // handshake logger, sampled well after the falling edge
  always @(negedge clk) begin
    #2;
    if (rstN && dirValid && dirReady && dirCnt < 64) begin
      dirOpLog[dirCnt]   = int'(dirOp);
      dirAddrLog[dirCnt] = int'(dirAddr);
      dirIdLog[dirCnt]   = int'(dirId);
      dirStamp[dirCnt]   = cycles;
      dirCnt++;
    end
    if (rstN && wbValid && wbReady && wbCnt < 64) begin
      wbAddrLog[wbCnt] = int'(wbAddr);
      wbStamp[wbCnt]   = cycles;
      wbCnt++;
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendReq(input logic [1:0] op, input logic [1:0] a, input logic [3:0] id);
    int waitN = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqId = id;
    #1;
    while (!reqReady && waitN < 200) begin
      @(negedge clk);
      #1;
      waitN++;
    end
    if (waitN >= 200) checkEq("accept", "request stuck", 0, 1);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic ackWb(input logic [1:0] a);
    @(negedge clk);
    wbAckValid = 1'b1; wbAckAddr = a;
    @(negedge clk);
    wbAckValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    #1;
    checkEq("R1", "reqReady", int'(reqReady), 1);
    checkEq("R1", "dirValid", int'(dirValid), 0);
    checkEq("R1", "wbValid", int'(wbValid), 0);
  endtask

  task automatic testWriteThrough();
    wbEnable = 1'b0;
    sendReq(2'd2, 2'd0, 4'd1);
    idle(3);
    checkEq("R2", "dir count", dirCnt, 1);
    checkEq("R2", "dir op", dirOpLog[0], 2);
    checkEq("R2", "dir id", dirIdLog[0], 1);
    sendReq(2'd1, 2'd1, 4'd2);
    idle(3);
    checkEq("R7", "dir count after write", dirCnt, 2);
    checkEq("R7", "write op", dirOpLog[1], 1);
    checkEq("R7", "write addr", dirAddrLog[1], 1);
    sendReq(2'd2, 2'd1, 4'd3);
    idle(3);
    checkEq("R7", "atomic after wt write id", dirIdLog[2], 3);
    checkEq("R7", "no write-back", wbCnt, 0);
  endtask

  task automatic testParkAndReplay();
    wbEnable = 1'b1;
    sendReq(2'd1, 2'd2, 4'd4);
    idle(3);
    checkEq("R8", "wb-mode write silent", dirCnt, 3);
    sendReq(2'd2, 2'd2, 4'd5);
    idle(5);
    checkEq("R3", "write-back count", wbCnt, 1);
    checkEq("R3", "write-back addr", wbAddrLog[0], 2);
    checkEq("R3", "atomic held", dirCnt, 3);
    sendReq(2'd1, 2'd2, 4'd6);
    sendReq(2'd2, 2'd2, 4'd7);
    sendReq(2'd2, 2'd3, 4'd8);
    idle(3);
    checkEq("R6", "other line count", dirCnt, 4);
    checkEq("R6", "other line id", dirIdLog[3], 8);
    ackWb(2'd2);
    idle(10);
    checkEq("R4", "dir count after ack", dirCnt, 5);
    checkEq("R4", "replayed atomic id", dirIdLog[4], 5);
    checkEq("R4", "wb before atomic", int'(dirStamp[4] > wbStamp[0]), 1);
    checkEq("R5", "second write-back", wbCnt, 2);
    checkEq("R5", "second wb addr", wbAddrLog[1], 2);
    ackWb(2'd2);
    idle(6);
    checkEq("R5", "dir count final", dirCnt, 6);
    checkEq("R5", "last atomic id", dirIdLog[5], 7);
    checkEq("R5", "last atomic addr", dirAddrLog[5], 2);
  endtask

  task automatic testHolds();
    @(negedge clk);
    dirReady = 1'b0;
    sendReq(2'd2, 2'd0, 4'd9);
    idle(2);
    checkEq("R9", "dirValid raised", int'(dirValid), 1);
    checkEq("R9", "dirId", int'(dirId), 9);
    idle(3);
    checkEq("R9", "dirValid held", int'(dirValid), 1);
    checkEq("R9", "dirId held", int'(dirId), 9);
    checkEq("R9", "dirAddr held", int'(dirAddr), 0);
    dirReady = 1'b1;
    idle(2);
    checkEq("R9", "dir count", dirCnt, 7);
    checkEq("R9", "dirValid dropped", int'(dirValid), 0);
    wbReady = 1'b0;
    sendReq(2'd1, 2'd1, 4'd10);
    sendReq(2'd2, 2'd1, 4'd11);
    idle(4);
    checkEq("R12", "wbValid held", int'(wbValid), 1);
    checkEq("R12", "wbAddr held", int'(wbAddr), 1);
    checkEq("R12", "no wb handshake", wbCnt, 2);
    wbReady = 1'b1;
    idle(2);
    checkEq("R12", "wb handshake", wbCnt, 3);
    ackWb(2'd1);
    idle(5);
    checkEq("R4", "atomic after held wb", dirIdLog[7], 11);
  endtask

  task automatic testTbeLimit();
    sendReq(2'd1, 2'd0, 4'd12);
    sendReq(2'd1, 2'd1, 4'd13);
    sendReq(2'd2, 2'd0, 4'd14);
    sendReq(2'd2, 2'd1, 4'd15);
    idle(3);
    #1;
    checkEq("R11", "ready low with no entry", int'(reqReady), 0);
    checkEq("R11", "write-backs", wbCnt, 5);
    ackWb(2'd0);
    idle(5);
    #1;
    checkEq("R11", "ready back", int'(reqReady), 1);
    checkEq("R11", "first atomic out", dirIdLog[8], 14);
    ackWb(2'd1);
    idle(5);
    checkEq("R11", "second atomic out", dirIdLog[9], 15);
  endtask

  task automatic testFull();
    sendReq(2'd1, 2'd3, 4'd1);
    sendReq(2'd2, 2'd3, 4'd2);
    sendReq(2'd0, 2'd3, 4'd3);
    sendReq(2'd0, 2'd3, 4'd4);
    sendReq(2'd0, 2'd3, 4'd5);
    idle(2);
    #1;
    checkEq("R10", "ready low when full", int'(reqReady), 0);
    ackWb(2'd3);
    idle(8);
    #1;
    checkEq("R10", "ready after drain", int'(reqReady), 1);
    checkEq("R10", "parked atomic id", dirIdLog[10], 2);
    sendReq(2'd2, 2'd3, 4'd6);
    idle(3);
    checkEq("R2", "clean line atomic", dirCnt, 12);
    checkEq("R2", "no extra wb", wbCnt, 6);
  endtask

  initial begin
    testReset();
    testWriteThrough();
    testParkAndReplay();
    testHolds();
    testTbeLimit();
    testFull();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule